// File: doc/BRIEF.md
# Programmable ROM Streaming Address Generator

This block streams bytes out of an external data ROM on behalf of a CPU that talks to it through a small byte-wide register bus. Software loads a 24-bit base pointer, a 16-bit adjust value and a 16-bit step value one byte at a time, then programs a mode byte. Each read of the main data port returns the byte at the base pointer, or at base plus adjust, and afterwards advances either the base pointer or the adjust value by one or by the step value. A secondary data port always returns the byte at base plus adjust. The mode byte also picks signed or unsigned treatment of the step and adjust values, and whether the adjust value is folded into the pointer when it is written or when the secondary port is read.

The ROM is a dual-read synchronous byte memory with one cycle of latency. The block drives both ROM addresses continuously from its registers, so the bytes for both ports are always fetched ahead of the next read. A bus read returns its byte on `regRdData` in the cycle after the read strobe. Consecutive bus accesses must be separated by at least one idle cycle, which gives the ROM time to follow a change of address.

Top module: `romstream_top`

## Requirements
- R1: After reset the base, adjust and step registers are zero, both ROM addresses are zero and streaming is disabled. While disabled, a read of offset 0 or 1 returns 0x00 on `regRdData` one cycle later and changes no register.
- R2: Streaming is enabled, and stays enabled until reset, by any write of a nonzero value to the bank byte (offset 4). This holds even if the bank byte is later rewritten as zero. Writing zero first does not enable it.
- R3: A read of the main port (offset 0) while enabled returns, one cycle after the strobe, the ROM byte at the base pointer when mode bit 1 is 0. When mode bit 1 is 1 it returns the byte at base plus adjust.
- R4: After each enabled main-port read the target is advanced by 1 when mode bit 0 is 0, and by the step value when mode bit 0 is 1. The step value is sign-extended when mode bit 2 is 1 and zero-extended otherwise.
- R5: Mode bit 4 picks the step target: 0 advances the 24-bit base pointer, and 1 advances the 16-bit adjust value, which wraps within 16 bits and leaves the base pointer unchanged.
- R6: A read of the secondary port (offset 1) while enabled returns the byte at base plus adjust. The adjust value is sign-extended to 24 bits when mode bit 3 is 1 and zero-extended otherwise, and the sum wraps at 24 bits. This holds for every mode.
- R7: A byte written to the mode register (offset 9, bits 6:0 used, bit 7 ignored) is held pending. It becomes active only on the write that completes a pair of adjust byte writes (offsets 5 and 6, in either order). Until then the previous mode stays in force.
- R8: On every adjust byte write, the policy in mode bits 6:5 of the mode in force after that write is applied. Policy 01 adds the low adjust byte (8 bits, extended per mode bit 3) to the base pointer, and policy 10 adds the full 16-bit adjust, extended per mode bit 3. Both adds use the adjust value that includes the byte just written.
- R9: With policy 11, each enabled secondary-port read adds the full extended adjust value to the base pointer after the byte is returned. Policy 00 never adds.
- R10: Register offsets are: 0 main port, 1 secondary port, 2/3/4 base low/middle/bank byte, 5/6 adjust low/high, 7/8 step low/high, 9 mode. A write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register offset |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Read data byte, valid the cycle after a port read |
| romMainAddr | output | 24 | ROM address for the main port |
| romAuxAddr | output | 24 | ROM address for the secondary port (base plus adjust) |
| romMainData | input | 8 | ROM byte at the previous cycle's main address |
| romAuxData | input | 8 | ROM byte at the previous cycle's secondary address |

## Verification
Every register of this block feeds an address output straight away. A wrong base, adjust or active mode therefore appears on `romMainAddr` or `romAuxAddr` in the cycle after the access that caused it, and on the returned byte at the next port read. The bench compares both address outputs after every access and every returned byte against an arithmetic model. It sweeps all 128 mode values with both adjust write orders, so a wrong extension, wrong step target, mode activated too early or missing policy add is caught within one access. A wrong enable state shows as a zero byte, or a nonzero byte, on the first port read.

// File: rtl/romstream_pkg.sv
package romstream_pkg;
  localparam int ADDR_W = 24;
  localparam int ADJ_W = 16;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 4;
  localparam int BASE_BYTES = ADDR_W / BYTE_W;
  localparam int ADJ_BYTES = ADJ_W / BYTE_W;

  localparam logic [REG_AW-1:0] OFF_MAIN = 4'd0;
  localparam logic [REG_AW-1:0] OFF_AUX = 4'd1;
  localparam logic [REG_AW-1:0] OFF_BASE = 4'd2;
  localparam logic [REG_AW-1:0] OFF_ADJ = OFF_BASE + 4'(BASE_BYTES);
  localparam logic [REG_AW-1:0] OFF_STEP = OFF_ADJ + 4'(ADJ_BYTES);
  localparam logic [REG_AW-1:0] OFF_MODE = OFF_STEP + 4'(ADJ_BYTES);
  localparam logic [REG_AW-1:0] OFF_BANK = OFF_ADJ - 4'd1;

  // bit order equals the mode byte bits 6:0
  typedef struct packed {
    logic [1:0] addPolicy;
    logic       stepToAdj;
    logic       adjSigned;
    logic       stepSigned;
    logic       mainUsesAdj;
    logic       stepFromReg;
  } modeT;

  typedef struct packed {
    logic [BASE_BYTES-1:0] wrBase;
    logic [ADJ_BYTES-1:0]  wrAdj;
    logic [ADJ_BYTES-1:0]  wrStep;
    logic                  stepMain;
    logic                  addAdjByte;
    logic                  addAdjFull;
    logic                  capMain;
    logic                  capAux;
    logic                  capZero;
    modeT                  mode;
  } strobeT;
endpackage

// File: rtl/romstream_ctrl.sv
module romstream_ctrl
  import romstream_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output strobeT            strobes,
  output logic              rdEnabled,
  output modeT              activeMode
);
  modeT pendMode;
  logic [ADJ_BYTES-1:0] seenAdj;
  logic [ADJ_BYTES-1:0] adjWr;
  logic isWr, isRd, anyAdjWr, pairDone, portRd;
  modeT curMode;

  assign isWr = regWrEn;
  assign isRd = regRdEn && !regWrEn;

  for (genvar i = 0; i < ADJ_BYTES; i++) begin : g_adjWr
    assign adjWr[i] = isWr && (regAddr == OFF_ADJ + REG_AW'(i));
  end

  assign anyAdjWr = |adjWr;
  assign pairDone = anyAdjWr && (&(adjWr | seenAdj));
  assign curMode  = pairDone ? pendMode : activeMode;
  assign portRd   = isRd && (regAddr == OFF_MAIN || regAddr == OFF_AUX);

  always_comb begin
    strobes = '0;
    for (int i = 0; i < BASE_BYTES; i++)
      strobes.wrBase[i] = isWr && (regAddr == OFF_BASE + REG_AW'(i));
    for (int i = 0; i < ADJ_BYTES; i++)
      strobes.wrStep[i] = isWr && (regAddr == OFF_STEP + REG_AW'(i));
    strobes.wrAdj      = adjWr;
    strobes.mode       = curMode;
    strobes.capMain    = isRd && regAddr == OFF_MAIN && rdEnabled;
    strobes.capAux     = isRd && regAddr == OFF_AUX && rdEnabled;
    strobes.capZero    = portRd && !rdEnabled;
    strobes.stepMain   = strobes.capMain;
    strobes.addAdjByte = anyAdjWr && curMode.addPolicy == 2'b01;
    strobes.addAdjFull = (anyAdjWr && curMode.addPolicy == 2'b10) ||
                         (strobes.capAux && curMode.addPolicy == 2'b11);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMode   <= '0;
      activeMode <= '0;
      seenAdj    <= '0;
      rdEnabled  <= 1'b0;
    end else begin
      if (isWr && regAddr == OFF_MODE)
        pendMode <= modeT'(regWrData[6:0]);
      if (pairDone) begin
        activeMode <= pendMode;
        seenAdj    <= '0;
      end else begin
        seenAdj <= seenAdj | adjWr;
      end
      if (isWr && regAddr == OFF_BANK && regWrData != '0)
        rdEnabled <= 1'b1;
    end
  end
endmodule

// File: rtl/romstream_datapath.sv
module romstream_datapath
  import romstream_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] romMainData,
  input  logic [BYTE_W-1:0] romAuxData,
  output logic [ADDR_W-1:0] romMainAddr,
  output logic [ADDR_W-1:0] romAuxAddr,
  output logic [BYTE_W-1:0] regRdData,
  output logic [ADDR_W-1:0] baseQ
);
  localparam int ADJ_EXT = ADDR_W - ADJ_W;
  localparam int BYTE_EXT = ADDR_W - BYTE_W;

  logic [ADJ_W-1:0]  adjQ, stepQ, adjNext;
  logic [ADDR_W-1:0] adjExt, adjByteExt, stepExt, incr, adjRegExt;
  modeT m;

  assign m = strobes.mode;

  // adjust value including a byte being written this cycle
  always_comb begin
    adjNext = adjQ;
    for (int i = 0; i < ADJ_BYTES; i++)
      if (strobes.wrAdj[i]) adjNext[i*BYTE_W +: BYTE_W] = regWrData;
  end

  assign adjExt     = m.adjSigned ? {{ADJ_EXT{adjNext[ADJ_W-1]}}, adjNext}
                                  : {{ADJ_EXT{1'b0}}, adjNext};
  assign adjByteExt = m.adjSigned ? {{BYTE_EXT{adjNext[BYTE_W-1]}}, adjNext[BYTE_W-1:0]}
                                  : {{BYTE_EXT{1'b0}}, adjNext[BYTE_W-1:0]};
  assign adjRegExt  = m.adjSigned ? {{ADJ_EXT{adjQ[ADJ_W-1]}}, adjQ}
                                  : {{ADJ_EXT{1'b0}}, adjQ};
  assign stepExt    = m.stepSigned ? {{ADJ_EXT{stepQ[ADJ_W-1]}}, stepQ}
                                   : {{ADJ_EXT{1'b0}}, stepQ};
  assign incr       = m.stepFromReg ? stepExt : ADDR_W'(1);

  assign romAuxAddr  = baseQ + adjRegExt;
  assign romMainAddr = m.mainUsesAdj ? romAuxAddr : baseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ     <= '0;
      adjQ      <= '0;
      stepQ     <= '0;
      regRdData <= '0;
    end else begin
      for (int i = 0; i < BASE_BYTES; i++)
        if (strobes.wrBase[i]) baseQ[i*BYTE_W +: BYTE_W] <= regWrData;
      for (int i = 0; i < ADJ_BYTES; i++)
        if (strobes.wrStep[i]) stepQ[i*BYTE_W +: BYTE_W] <= regWrData;

      if (strobes.addAdjFull)
        baseQ <= baseQ + adjExt;
      else if (strobes.addAdjByte)
        baseQ <= baseQ + adjByteExt;
      else if (strobes.stepMain && !m.stepToAdj)
        baseQ <= baseQ + incr;

      if (strobes.stepMain && m.stepToAdj)
        adjQ <= adjQ + incr[ADJ_W-1:0];
      else
        adjQ <= adjNext;

      if (strobes.capMain)
        regRdData <= romMainData;
      else if (strobes.capAux)
        regRdData <= romAuxData;
      else if (strobes.capZero)
        regRdData <= '0;
    end
  end
endmodule

// File: rtl/romstream_top.sv
module romstream_top
  import romstream_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic [ADDR_W-1:0] romMainAddr,
  output logic [ADDR_W-1:0] romAuxAddr,
  input  logic [BYTE_W-1:0] romMainData,
  input  logic [BYTE_W-1:0] romAuxData
);
  strobeT strobes;
  logic   rdEnabled;
  modeT   activeMode;
  logic [ADDR_W-1:0] baseQ;

  romstream_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .strobes(strobes),
    .rdEnabled(rdEnabled), .activeMode(activeMode)
  );

  romstream_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .romMainData(romMainData), .romAuxData(romAuxData),
    .romMainAddr(romMainAddr), .romAuxAddr(romAuxAddr),
    .regRdData(regRdData), .baseQ(baseQ)
  );
endmodule

// File: rtl/romstream_checker.sv
module romstream_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [3:0]  regAddr,
  input logic [7:0]  regRdData,
  input logic [23:0] romAuxAddr,
  input logic [7:0]  romMainData,
  input logic        rdEnabled,
  input logic [6:0]  activeMode,
  input logic [23:0] baseQ
);
  logic mainRd, portRd, adjWr;
  assign mainRd = regRdEn && !regWrEn && regAddr == 4'd0;
  assign portRd = regRdEn && !regWrEn && (regAddr == 4'd0 || regAddr == 4'd1);
  assign adjWr  = regWrEn && (regAddr == 4'd5 || regAddr == 4'd6);

  assert_disabled_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    portRd && !rdEnabled |=> regRdData == 8'h00);

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdEnabled |=> rdEnabled);

  assert_main_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    mainRd && rdEnabled |=> regRdData == $past(romMainData));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    mainRd && rdEnabled && !activeMode[0] && !activeMode[4]
    |=> romAuxAddr == $past(romAuxAddr) + 24'd1);

  assert_adj_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    mainRd && rdEnabled && activeMode[4] |=> $stable(baseQ));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !adjWr |=> $stable(activeMode));
endmodule

bind romstream_top romstream_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regRdData(regRdData), .romAuxAddr(romAuxAddr),
  .romMainData(romMainData), .rdEnabled(rdEnabled),
  .activeMode(activeMode), .baseQ(baseQ)
);

// File: tb/romstream_top_tb.sv
module romstream_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData, romMainData, romAuxData;
  logic [23:0] romMainAddr, romAuxAddr;

  int nChecks = 0, nFail = 0, cycles = 0;
  bit done = 0;

  // model state
  logic [23:0] mBase;
  logic [15:0] mAdj, mStep;
  logic [6:0]  mAct, mPend;
  bit seenLo, seenHi, mEn;

  always #2 clk = ~clk;

  romstream_top u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .romMainAddr(romMainAddr), .romAuxAddr(romAuxAddr),
    .romMainData(romMainData), .romAuxData(romAuxData)
  );

  function automatic logic [7:0] romByte(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) begin
    romMainData <= romByte(romMainAddr);
    romAuxData  <= romByte(romAuxAddr);
  end

  function automatic logic [23:0] ext16(logic [15:0] v, logic s);
    return s ? {{8{v[15]}}, v} : {8'h00, v};
  endfunction
  function automatic logic [23:0] ext8(logic [7:0] v, logic s);
    return s ? {{16{v[7]}}, v} : {16'h0000, v};
  endfunction
  function automatic logic [23:0] auxA();
    return mBase + ext16(mAdj, mAct[3]);
  endfunction
  function automatic logic [23:0] mainA();
    return mAct[1] ? auxA() : mBase;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAddrs(string req);
    check(req, {8'h0, romMainAddr}, {8'h0, mainA()});
    check(req, {8'h0, romAuxAddr}, {8'h0, auxA()});
  endtask

  task automatic regWrite(logic [3:0] a, logic [7:0] d);
    bit lo, both;
    logic [6:0] eff;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      4'd2: mBase[7:0] = d;
      4'd3: mBase[15:8] = d;
      4'd4: begin mBase[23:16] = d; if (d != 0) mEn = 1; end
      4'd5, 4'd6: begin
        lo = (a == 4'd5);
        if (lo) mAdj[7:0] = d; else mAdj[15:8] = d;
        both = (lo || seenLo) && (!lo || seenHi);
        eff = both ? mPend : mAct;
        if (both) begin mAct = mPend; seenLo = 0; seenHi = 0; end
        else if (lo) seenLo = 1; else seenHi = 1;
        if (eff[6:5] == 2'b01) mBase = mBase + ext8(mAdj[7:0], eff[3]);
        if (eff[6:5] == 2'b10) mBase = mBase + ext16(mAdj, eff[3]);
      end
      4'd7: mStep[7:0] = d;
      4'd8: mStep[15:8] = d;
      4'd9: mPend = d[6:0];
      default: ;
    endcase
  endtask

  task automatic readMain(string req);
    logic [7:0] exp;
    logic [23:0] inc;
    exp = mEn ? romByte(mainA()) : 8'h00;
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 4'd0;
    @(negedge clk);
    regRdEn = 1'b0;
    check(req, {24'h0, regRdData}, {24'h0, exp});
    if (mEn) begin
      inc = mAct[0] ? ext16(mStep, mAct[2]) : 24'd1;
      if (mAct[4]) mAdj = mAdj + inc[15:0];
      else mBase = mBase + inc;
    end
    checkAddrs(req);
  endtask

  task automatic readAux(string req);
    logic [7:0] exp;
    exp = mEn ? romByte(auxA()) : 8'h00;
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 4'd1;
    @(negedge clk);
    regRdEn = 1'b0;
    check(req, {24'h0, regRdData}, {24'h0, exp});
    if (mEn && mAct[6:5] == 2'b11) mBase = mBase + ext16(mAdj, mAct[3]);
    checkAddrs(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog actual %0d expected below 200000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    mBase = '0; mAdj = '0; mStep = '0; mAct = '0; mPend = '0;
    seenLo = 0; seenHi = 0; mEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state and disabled ports
    checkAddrs("R1 reset addresses");
    regWrite(4'd2, 8'h40);
    readMain("R1 disabled main read");
    readAux("R1 disabled aux read");

    // R2 zero bank write does not enable, nonzero then zero does
    regWrite(4'd4, 8'h00);
    readMain("R2 still disabled after zero bank");
    regWrite(4'd4, 8'h07);
    regWrite(4'd4, 8'h00);
    readMain("R2 enabled after nonzero bank");
    readAux("R2 aux enabled");

    // R10 unused offsets change nothing
    regWrite(4'd10, 8'hFF);
    regWrite(4'd15, 8'h81);
    checkAddrs("R10 unused offset write");

    // sweep all modes, both adjust orders
    for (int m = 0; m < 256; m++) begin
      logic [7:0] ab0, ab1;
      ab0 = 8'(m * 37 + 5);
      ab1 = 8'(m * 91 + 3);
      regWrite(4'd2, 8'(m * 5));
      regWrite(4'd3, ~8'(m));
      regWrite(4'd4, 8'(m));
      regWrite(4'd7, 8'(m * 13 + 1));
      regWrite(4'd8, 8'(m * 29) ^ 8'h80);
      regWrite(4'd9, 8'(m));
      checkAddrs("R7 mode pending after mode write");
      if (m[7]) regWrite(4'd6, ab1); else regWrite(4'd5, ab0);
      checkAddrs("R7 R8 first adjust byte");
      readMain("R3 R4 R5 R7 main read before pair completes");
      if (m[7]) regWrite(4'd5, ab0); else regWrite(4'd6, ab1);
      checkAddrs("R7 R8 pair completes");
      readMain("R3 R4 R5 main read new mode");
      readMain("R3 R4 R5 second main read");
      readAux("R6 R9 aux read");
      readAux("R6 R9 second aux read");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule